// File: doc/BRIEF.md
# Compare-Match Watchdog Reset Unit

This unit is a watchdog made from one channel of a counter array. A free-running 16-bit timer advances on a count-enable strobe. Software loads a 16-bit compare value one byte at a time. When the timer reaches the compare value while the channel's compare function and the watchdog enable are both on, the unit issues a one-cycle internal reset. Software keeps the system alive by moving the compare value ahead of the timer before they meet. It can also stop the watchdog by clearing its enable bit before a match and setting it again later.

The same channel still works as an ordinary compare channel when the watchdog is off. It signals each match on `match_o` if its match bit is set. The external reset pin output is never driven by a watchdog event.

All state is reached through a byte-wide register port with these addresses: 0 is timer low byte, 1 is timer high byte, 2 is compare low byte, 3 is compare high byte, 4 is the counter mode register and 5 is the channel mode register. Other addresses read as zero.

Top module: `wdt_cmp_top`

## Requirements
- R1: After reset, every register reads 0x00, and `int_rst_o`, `match_o` and `ext_rst_o` are low.
- R2: The timer adds one on each clock with `cnt_en_i` high and wraps from 0xFFFF to 0x0000. A write to address 0 or 1 loads that timer byte and takes priority over counting. Addresses 0 and 1 read back the current timer bytes.
- R3: A write to address 2 loads the compare low byte and clears channel mode bit 6, the compare enable. A write to address 3 loads the compare high byte and sets bit 6.
- R4: A match requires all three of: the timer value changed on the last edge, the timer equals the compare value, and compare enable is set. A match with channel mode bit 3 (match bit) set gives a one-cycle `match_o` pulse on the next edge.
- R5: A match while counter mode bit 6 (watchdog enable, mask 0x40) is set gives a one-cycle `int_rst_o` pulse on the next edge. The match bit does not affect this.
- R6: A timer that holds its value never produces a second pulse. Setting compare enable while the timer already equals the compare value produces no pulse.
- R7: With watchdog enable clear, a match produces no `int_rst_o`, but `match_o` still pulses. Setting the bit again re-arms the reset.
- R8: `ext_rst_o` stays low at all times, including when `int_rst_o` fires.
- R9: The counter mode register is a full 8-bit read/write register, so a read-modify-write keeps its other bits. The channel mode register holds bits 6..0, and bit 7 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 1 | Timer count enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| match_o | output | 1 | Compare match pulse |
| int_rst_o | output | 1 | Internal watchdog reset pulse |
| ext_rst_o | output | 1 | External reset pin drive (always low) |

## Verification
The assertions assume a write strobe targets only one address per cycle. They also assume no timer write puts back the same value it held two cycles before, which is what makes back-to-back resets impossible. The stimulus keeps to this in two ways: each write lasts exactly one cycle, and every timer write moves the timer to a value it did not hold on the previous edge. Counting is enabled only for a known number of cycles, so the cycle of each expected pulse can be computed ahead of time and placed in the scoreboard queue.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int A_TLO  = 0;
  localparam int A_THI  = 1;
  localparam int A_CLO  = 2;
  localparam int A_CHI  = 3;
  localparam int A_MODE = 4;
  localparam int A_CHAN = 5;

  localparam int WDE_BIT  = 6;  // counter mode: watchdog enable
  localparam int ECOM_BIT = 6;  // channel mode: compare enable
  localparam int MAT_BIT  = 3;  // channel mode: match pulse enable
  localparam int CH_W     = 7;  // channel mode width
endpackage

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cnt_en_i,
  input  logic            wr_lo_i,
  input  logic            wr_hi_i,
  input  logic [DW-1:0]   wr_data_i,
  output logic [2*DW-1:0] tmr_o,
  output logic            chg_o
);
  localparam int TW = 2 * DW;

  logic [TW-1:0] tmr_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= tmr_q;
      if (wr_lo_i) tmr_q[DW-1:0]  <= wr_data_i;
      if (wr_hi_i) tmr_q[TW-1:DW] <= wr_data_i;
      if (!wr_lo_i && !wr_hi_i && cnt_en_i) tmr_q <= tmr_q + TW'(1);
    end
  end

  assign tmr_o = tmr_q;
  // match is only evaluated on a fresh timer value
  assign chg_o = (tmr_q != prev_q);

  // R2
  tmr_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !wr_lo_i && !wr_hi_i) |=> tmr_q == $past(tmr_q + TW'(1)));
  // R2
  tmr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !wr_lo_i && !wr_hi_i && tmr_q == '1) |=> tmr_q == '0);
endmodule

// File: rtl/wdt_cmp_chan.sv
module wdt_cmp_chan
  import wdt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_lo_i,
  input  logic            wr_hi_i,
  input  logic            wr_mode_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic [2*DW-1:0] tmr_i,
  input  logic            chg_i,
  output logic [2*DW-1:0] cmp_o,
  output logic [CH_W-1:0] mode_o,
  output logic            hit_o,
  output logic            match_o
);
  localparam int TW = 2 * DW;

  logic [TW-1:0]   cmp_q;
  logic [CH_W-1:0] mode_q;
  logic            match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q   <= '0;
      mode_q  <= '0;
      match_q <= 1'b0;
    end else begin
      if (wr_mode_i) mode_q <= wr_data_i[CH_W-1:0];
      // low byte disarms, high byte re-arms: no match on a half-written value
      if (wr_lo_i) begin
        cmp_q[DW-1:0]    <= wr_data_i;
        mode_q[ECOM_BIT] <= 1'b0;
      end
      if (wr_hi_i) begin
        cmp_q[TW-1:DW]   <= wr_data_i;
        mode_q[ECOM_BIT] <= 1'b1;
      end
      match_q <= hit_o && mode_q[MAT_BIT];
    end
  end

  assign hit_o   = chg_i && mode_q[ECOM_BIT] && (tmr_i == cmp_q);
  assign cmp_o   = cmp_q;
  assign mode_o  = mode_q;
  assign match_o = match_q;

  // R3
  cmp_lo_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && !wr_mode_i) |=> !mode_q[ECOM_BIT]);
  // R3
  cmp_hi_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hi_i && !wr_mode_i) |=> mode_q[ECOM_BIT]);
  // R4
  match_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_q |=> !match_q);
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_mode_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          hit_i,
  output logic [DW-1:0] mode_o,
  output logic          int_rst_o
);
  logic [DW-1:0] mode_q;
  logic          rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      rst_q  <= 1'b0;
    end else begin
      if (wr_mode_i) mode_q <= wr_data_i;
      rst_q <= hit_i && mode_q[WDE_BIT];
    end
  end

  assign mode_o    = mode_q;
  assign int_rst_o = rst_q;

  // R5
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> !rst_q);
  // R7
  rst_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q[WDE_BIT] && !wr_mode_i) |=> !rst_q);
endmodule

// File: rtl/wdt_cmp_top.sv
module wdt_cmp_top
  import wdt_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cnt_en_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          match_o,
  output logic          int_rst_o,
  output logic          ext_rst_o
);
  localparam int TW = 2 * DW;

  logic          wr_tlo, wr_thi, wr_clo, wr_chi, wr_mode, wr_chan;
  logic [TW-1:0] tmr, cmp;
  logic          chg, hit;
  logic [CH_W-1:0] ch_mode;
  logic [DW-1:0] cnt_mode;

  assign wr_tlo  = wr_en_i && (wr_addr_i == AW'(A_TLO));
  assign wr_thi  = wr_en_i && (wr_addr_i == AW'(A_THI));
  assign wr_clo  = wr_en_i && (wr_addr_i == AW'(A_CLO));
  assign wr_chi  = wr_en_i && (wr_addr_i == AW'(A_CHI));
  assign wr_mode = wr_en_i && (wr_addr_i == AW'(A_MODE));
  assign wr_chan = wr_en_i && (wr_addr_i == AW'(A_CHAN));

  wdt_timer #(.DW(DW)) u_timer (
    .clk_i, .rst_ni, .cnt_en_i,
    .wr_lo_i(wr_tlo), .wr_hi_i(wr_thi), .wr_data_i,
    .tmr_o(tmr), .chg_o(chg)
  );

  wdt_cmp_chan #(.DW(DW)) u_chan (
    .clk_i, .rst_ni,
    .wr_lo_i(wr_clo), .wr_hi_i(wr_chi), .wr_mode_i(wr_chan), .wr_data_i,
    .tmr_i(tmr), .chg_i(chg),
    .cmp_o(cmp), .mode_o(ch_mode), .hit_o(hit), .match_o
  );

  wdt_ctrl #(.DW(DW)) u_ctrl (
    .clk_i, .rst_ni,
    .wr_mode_i(wr_mode), .wr_data_i,
    .hit_i(hit), .mode_o(cnt_mode), .int_rst_o
  );

  // watchdog reset is internal only
  assign ext_rst_o = 1'b0;

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      AW'(A_TLO):  rd_data_o = tmr[DW-1:0];
      AW'(A_THI):  rd_data_o = tmr[TW-1:DW];
      AW'(A_CLO):  rd_data_o = cmp[DW-1:0];
      AW'(A_CHI):  rd_data_o = cmp[TW-1:DW];
      AW'(A_MODE): rd_data_o = cnt_mode;
      AW'(A_CHAN): rd_data_o = {{(DW-CH_W){1'b0}}, ch_mode};
      default:     rd_data_o = '0;
    endcase
  end

  // R5
  rst_on_eq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rst_o |-> $past(tmr == cmp));
  // R6
  stall_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(tmr) |=> !int_rst_o);
  // R4
  match_on_eq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(tmr == cmp));
endmodule

// File: tb/tb_wdt_cmp_top.sv
module tb_wdt_cmp_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       match_o, int_rst_o, ext_rst_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc;
  int q_rst[$];
  int q_mat[$];

  always #10 clk = ~clk;  // 50 MHz

  wdt_cmp_top dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .match_o(match_o), .int_rst_o(int_rst_o), .ext_rst_o(ext_rst_o)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic report(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pop expected pulse cycles as pulses appear
  always @(negedge clk) if (rst_n) begin
    if (int_rst_o) begin
      report(ext_rst_o == 1'b0, "R8 ext pin", ext_rst_o, 0);
      if (q_rst.size() == 0) report(0, "R5/R6 unexpected reset", cyc, -1);
      else report(q_rst.pop_front() == cyc, "R5 reset cycle", cyc, -1);
    end
    if (match_o) begin
      if (q_mat.size() == 0) report(0, "R4/R7 unexpected match", cyc, -1);
      else report(q_mat.pop_front() == cyc, "R4 match cycle", cyc, -1);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    rd_addr = a;
    #1;
    report(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int c;
    logic [7:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 6; a++) rd_chk(3'(a), 8'h00, "R1 reg reset");
    report({int_rst_o, match_o, ext_rst_o} == 3'b000, "R1 outputs", {int_rst_o, match_o, ext_rst_o}, 0);

    // R9 channel mode: bit 7 not stored
    wr(5, 8'hCC);
    rd_chk(5, 8'h4C, "R9 chan bit7");
    // R9 counter mode read-modify-write
    wr(4, 8'h05);
    rd_chk(4, 8'h05, "R9 mode write");
    m = rd_data | 8'h40;
    wr(4, m);
    rd_chk(4, 8'h45, "R9 mode rmw");

    // R3 compare enable sequencing
    wr(2, 8'h34);
    rd_chk(5, 8'h0C, "R3 low clears enable");
    wr(3, 8'h12);
    rd_chk(5, 8'h4C, "R3 high sets enable");
    rd_chk(2, 8'h34, "R3 cmp low");
    rd_chk(3, 8'h12, "R3 cmp high");

    // R5 match by timer write
    wr(1, 8'h12);
    wr(0, 8'h34);
    q_rst.push_back(cyc + 1); q_mat.push_back(cyc + 1);
    idle(6);  // R6 stalled timer: no repeat
    rd_chk(0, 8'h34, "R2 timer low");
    rd_chk(1, 8'h12, "R2 timer high");

    // R2/R5 counting to a match
    wr(1, 8'h00);
    wr(0, 8'h05);
    wr(2, 8'h10);
    wr(3, 8'h00);
    @(negedge clk);
    c = cyc; cnt_en = 1'b1;
    q_rst.push_back(c + 12); q_mat.push_back(c + 12);
    repeat (20) @(negedge clk);
    cnt_en = 1'b0;
    rd_chk(0, 8'h19, "R2 count");

    // R2 wrap
    wr(2, 8'h01);
    wr(3, 8'h00);
    wr(1, 8'hFF);
    wr(0, 8'hFE);
    @(negedge clk);
    c = cyc; cnt_en = 1'b1;
    q_rst.push_back(c + 4); q_mat.push_back(c + 4);
    repeat (3) @(negedge clk);
    cnt_en = 1'b0;
    rd_chk(0, 8'h01, "R2 wrap low");
    rd_chk(1, 8'h00, "R2 wrap high");

    // R6 compare disabled during match, enabling on a stable equal timer
    wr(2, 8'h40);
    wr(0, 8'h40);
    wr(3, 8'h00);
    idle(4);
    rd_chk(5, 8'h4C, "R6 enable back on");

    // R7 watchdog off: match only
    wr(4, 8'h05);
    wr(0, 8'h3F);
    wr(0, 8'h40);
    q_mat.push_back(cyc + 1);
    idle(4);
    // R7 re-arm
    wr(4, 8'h45);
    wr(0, 8'h3F);
    wr(0, 8'h40);
    q_rst.push_back(cyc + 1); q_mat.push_back(cyc + 1);
    idle(4);
    // R5 reset independent of match bit
    wr(5, 8'h44);
    wr(0, 8'h3F);
    wr(0, 8'h40);
    q_rst.push_back(cyc + 1);
    idle(4);

    report(q_rst.size() == 0, "R5 missing resets", q_rst.size(), 0);
    report(q_mat.size() == 0, "R4 missing matches", q_mat.size(), 0);
    report(ext_rst_o == 1'b0, "R8 ext idle", ext_rst_o, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule